// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the CPU-side sequencer for a single-level interrupt scheme. Each cycle it looks at the combined, already-masked request vector, the global enable and its own in-service flag, and decides whether to take an interrupt. When it takes one, the following cycle is a stall cycle. In that cycle it cancels the instruction fetch, pushes the return address to the stack, raises the in-service flag and steers the instruction pointer to the vector address. When the decoder reports a return-from-interrupt, the block pops the stack, reloads the instruction pointer from the popped word and drops the in-service flag.

The block also owns the one-cycle prefix register. A value written there lives for exactly the next clock. That cycle is an exception window in which no interrupt is taken, so a prefix and the instruction that consumes it are never split. Software can write the in-service flag directly; clearing it inside a handler allows nesting. The stack memory, the datapath and per-source masking sit outside the block. All pins are plain level or strobe signals with no flow control, because the pipeline around the block advances one instruction per cycle.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the in-service flag is 0, no stall is in progress, the prefix value is 0, and every strobe (`irq_ack`, `fetch_cancel`, `push_stb`, `pop_stb`, `ip_load`) is 0.
- R2: `irq_ack` is 1 in a cycle exactly when `gie` is 1, `in_service` is 0, `irq_req` is nonzero, no exception window is open, no effective return-from-interrupt is decoded, and no stall is in progress.
- R3: The cycle after `irq_ack` is the single stall cycle. In it, `fetch_cancel`, `push_stb` and `ip_load` are 1, `push_addr` equals the `ret_addr` sampled in the acknowledge cycle, `ip_next` equals the `ivec` sampled in the acknowledge cycle, and `in_service` reads 1.
- R4: While `in_service` is 1, no request is acknowledged.
- R5: A software write (`dec_ins_wr`) loads `ins_wdata` into the in-service flag on the next edge. An acknowledge in the same cycle takes priority and sets the flag. A return-from-interrupt in the same cycle also takes priority and clears it.
- R6: An effective return-from-interrupt gives `pop_stb`=1, `ip_load`=1 and `ip_next`=`pop_addr` in the same cycle, and `in_service` reads 0 from the next cycle.
- R7: No request is acknowledged in the cycle of an effective return-from-interrupt. At the earliest, the acknowledge comes in the next cycle, so the next push comes two cycles after the return.
- R8: When `dec_pfx_wr` is accepted, `pfx_value` shows `pfx_wdata` during the next cycle only and returns to 0 after that unless it is written again.
- R9: `exc_window` is 1 in the cycle after an accepted prefix write. No request is acknowledged in that cycle, so a request pending there is acknowledged one cycle later.
- R10: During the stall cycle, the decode strobes `dec_reti`, `dec_pfx_wr` and `dec_ins_wr` are ignored. As a result, `push_stb` and `pop_stb` are never 1 together.
- R11: When no load is requested, `ip_next` is 0 and `ip_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| irq_req | input | NSRC | Masked pending requests, one bit per module |
| dec_reti | input | 1 | Decoder: return-from-interrupt this cycle |
| dec_pfx_wr | input | 1 | Decoder: prefix register write this cycle |
| pfx_wdata | input | PFX_W | Value written to the prefix register |
| dec_ins_wr | input | 1 | Decoder: software write of the in-service flag |
| ins_wdata | input | 1 | Value for the in-service flag |
| ivec | input | ADDR_W | Interrupt vector register value |
| ret_addr | input | ADDR_W | Address to resume after the handler |
| pop_addr | input | ADDR_W | Word read from the stack top |
| irq_ack | output | 1 | Request acknowledged this cycle |
| fetch_cancel | output | 1 | Cancel the fetch (stall cycle) |
| push_stb | output | 1 | Push `push_addr` onto the stack |
| push_addr | output | ADDR_W | Return address to push |
| pop_stb | output | 1 | Pop the stack |
| ip_load | output | 1 | Load the instruction pointer from `ip_next` |
| ip_next | output | ADDR_W | New instruction pointer value |
| in_service | output | 1 | In-service flag |
| pfx_value | output | PFX_W | Current prefix value (0 when not held) |
| exc_window | output | 1 | Exception window open this cycle |

## Verification
The hardest situations to reach are the ones where a request meets the in-service flag already at 0 while a return or a prefix window is in flight. These only arise after software has cleared the flag inside a handler. The bench first writes `ins_wdata`=0 through `dec_ins_wr` and then issues a return-from-interrupt while a request is held. It also issues prefix writes back to back while a request waits. In addition, it places decode strobes in the stall cycle to show they are dropped. A long run of random decode, enable and request patterns is then compared each cycle with a behavioural model, which reaches these overlaps many more times.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // How the in-service flag changes on the coming edge.
  typedef enum logic [1:0] {
    INS_HOLD = 2'd0,
    INS_SET  = 2'd1,
    INS_CLR  = 2'd2,
    INS_SW   = 2'd3
  } ins_op_e;

  // Acknowledge wins, then return-from-interrupt, then software write.
  function automatic ins_op_e pick_ins_op(input logic ack,
                                          input logic reti,
                                          input logic sw_wr);
    ins_op_e op;
    if (ack)        op = INS_SET;
    else if (reti)  op = INS_CLR;
    else if (sw_wr) op = INS_SW;
    else            op = INS_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/irq_pfx_window.sv
module irq_pfx_window #(
  parameter int PFX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_eff,
  input  logic [PFX_W-1:0] wdata,
  output logic [PFX_W-1:0] pfx_value,
  output logic             window
);

  logic             held_q;
  logic [PFX_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      val_q  <= '0;
    end else if (wr_eff) begin
      held_q <= 1'b1;
      val_q  <= wdata;
    end else begin
      held_q <= 1'b0;
      val_q  <= '0;
    end
  end

  assign pfx_value = val_q;
  assign window    = held_q;

  // R8: without a fresh write the prefix is gone the next cycle
  p_pfx_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_eff |=> (window == 1'b0 && pfx_value == '0));

  // R8: a write shows up in the next cycle
  p_pfx_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eff |=> (window && pfx_value == $past(wdata)));

endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gie,
  input  logic req_any,
  input  logic window,
  input  logic reti_eff,
  input  logic ins_wr_eff,
  input  logic ins_wdata,
  output logic ack,
  output logic stall,
  output logic ins
);

  logic    ins_q;
  logic    stall_q;
  ins_op_e op;

  always_comb begin
    ack = gie & ~ins_q & req_any & ~window & ~reti_eff & ~stall_q;
    op  = pick_ins_op(ack, reti_eff, ins_wr_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      stall_q <= ack;
      unique case (op)
        INS_SET:  ins_q <= 1'b1;
        INS_CLR:  ins_q <= 1'b0;
        INS_SW:   ins_q <= ins_wdata;
        default:  ins_q <= ins_q;
      endcase
    end
  end

  assign stall = stall_q;
  assign ins   = ins_q;

  // R3: acknowledge is followed by the stall with the flag raised
  p_ack_then_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (stall && ins));

  // R4: no acknowledge while in service
  p_no_ack_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins |-> !ack);

  // R2: acknowledge needs enable and a pending request
  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (gie && req_any));

  // R9: exception window blocks acknowledge
  p_no_ack_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    window |-> !ack);

  // R6: return clears the flag
  p_reti_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reti_eff |=> !ins);

  // R7: no acknowledge in a return cycle
  p_no_ack_on_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reti_eff |-> !ack);

endmodule

// File: rtl/irq_step_out.sv
module irq_step_out #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              stall,
  input  logic              reti_eff,
  input  logic [ADDR_W-1:0] ivec,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic              fetch_cancel,
  output logic              push_stb,
  output logic [ADDR_W-1:0] push_addr,
  output logic              pop_stb,
  output logic              ip_load,
  output logic [ADDR_W-1:0] ip_next
);

  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      ret_q <= '0;
    end else if (ack) begin
      vec_q <= ivec;
      ret_q <= ret_addr;
    end
  end

  always_comb begin
    fetch_cancel = stall;
    push_stb     = stall;
    push_addr    = stall ? ret_q : '0;
    pop_stb      = reti_eff;
    ip_load      = stall | reti_eff;
    if (stall)         ip_next = vec_q;
    else if (reti_eff) ip_next = pop_addr;
    else               ip_next = '0;
  end

  // R10: stack push and pop never collide
  p_push_pop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_stb && pop_stb));

  // R7: a return is never followed directly by a push
  p_gap_after_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_stb |=> !push_stb);

  // R3: the pushed word is the one sampled at acknowledge
  p_push_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (push_addr == $past(ret_addr)));

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
  parameter int ADDR_W = 16,
  parameter int PFX_W  = 8,
  parameter int NSRC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              dec_reti,
  input  logic              dec_pfx_wr,
  input  logic [PFX_W-1:0]  pfx_wdata,
  input  logic              dec_ins_wr,
  input  logic              ins_wdata,
  input  logic [ADDR_W-1:0] ivec,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic              irq_ack,
  output logic              fetch_cancel,
  output logic              push_stb,
  output logic [ADDR_W-1:0] push_addr,
  output logic              pop_stb,
  output logic              ip_load,
  output logic [ADDR_W-1:0] ip_next,
  output logic              in_service,
  output logic [PFX_W-1:0]  pfx_value,
  output logic              exc_window
);

  logic stall;
  logic req_any;
  logic reti_eff;
  logic pfx_wr_eff;
  logic ins_wr_eff;

  // Decode strobes are void during the stall cycle (cancelled fetch).
  assign req_any    = |irq_req;
  assign reti_eff   = dec_reti   & ~stall;
  assign pfx_wr_eff = dec_pfx_wr & ~stall;
  assign ins_wr_eff = dec_ins_wr & ~stall;

  irq_pfx_window #(.PFX_W(PFX_W)) u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_eff    (pfx_wr_eff),
    .wdata     (pfx_wdata),
    .pfx_value (pfx_value),
    .window    (exc_window)
  );

  irq_accept_ctl u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .gie        (gie),
    .req_any    (req_any),
    .window     (exc_window),
    .reti_eff   (reti_eff),
    .ins_wr_eff (ins_wr_eff),
    .ins_wdata  (ins_wdata),
    .ack        (irq_ack),
    .stall      (stall),
    .ins        (in_service)
  );

  irq_step_out #(.ADDR_W(ADDR_W)) u_step (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack          (irq_ack),
    .stall        (stall),
    .reti_eff     (reti_eff),
    .ivec         (ivec),
    .ret_addr     (ret_addr),
    .pop_addr     (pop_addr),
    .fetch_cancel (fetch_cancel),
    .push_stb     (push_stb),
    .push_addr    (push_addr),
    .pop_stb      (pop_stb),
    .ip_load      (ip_load),
    .ip_next      (ip_next)
  );

  // R10: decode strobes in the stall cycle leave the prefix untouched
  p_stall_ignores_pfx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cancel |=> !exc_window);

endmodule

// File: tb/irq_seq_top_tb_top.sv
module irq_seq_top_tb_top;
  localparam int ADDR_W = 16;
  localparam int PFX_W  = 8;
  localparam int NSRC   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gie = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic dec_reti = 1'b0, dec_pfx_wr = 1'b0, dec_ins_wr = 1'b0, ins_wdata = 1'b0;
  logic [PFX_W-1:0] pfx_wdata = '0;
  logic [ADDR_W-1:0] ivec = '0, ret_addr = '0, pop_addr = '0;
  logic irq_ack, fetch_cancel, push_stb, pop_stb, ip_load, in_service, exc_window;
  logic [ADDR_W-1:0] push_addr, ip_next;
  logic [PFX_W-1:0] pfx_value;

  always #10 clk = ~clk;

  irq_seq_top #(.ADDR_W(ADDR_W), .PFX_W(PFX_W), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .gie(gie), .irq_req(irq_req),
    .dec_reti(dec_reti), .dec_pfx_wr(dec_pfx_wr), .pfx_wdata(pfx_wdata),
    .dec_ins_wr(dec_ins_wr), .ins_wdata(ins_wdata), .ivec(ivec),
    .ret_addr(ret_addr), .pop_addr(pop_addr), .irq_ack(irq_ack),
    .fetch_cancel(fetch_cancel), .push_stb(push_stb), .push_addr(push_addr),
    .pop_stb(pop_stb), .ip_load(ip_load), .ip_next(ip_next),
    .in_service(in_service), .pfx_value(pfx_value), .exc_window(exc_window)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_ins = 0, m_stall = 0, m_pfx_v = 0, m_pfx = 0, m_ret = 0, m_vec = 0;
  int last_pop_cyc = -10, last_push_cyc = -10, cyc = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // One cycle: drive at negedge, compare, then advance the model at posedge.
  task automatic tick(input bit g, input int rq, input bit rt, input bit pw,
                      input int pd, input bit iw, input bit iv);
    int stl, reti_e, ack, pop, ld, ipn, nins;
    @(negedge clk);
    gie = g; irq_req = rq[NSRC-1:0]; dec_reti = rt; dec_pfx_wr = pw;
    pfx_wdata = pd[PFX_W-1:0]; dec_ins_wr = iw; ins_wdata = iv;
    ivec = 16'($urandom); ret_addr = 16'($urandom); pop_addr = 16'($urandom);
    #2;
    stl    = m_stall;
    reti_e = (rt && !stl) ? 1 : 0;
    ack    = (g && m_ins == 0 && rq != 0 && m_pfx_v == 0 && !reti_e && !stl) ? 1 : 0;
    pop    = reti_e;
    ld     = (stl || pop) ? 1 : 0;
    ipn    = stl ? m_vec : (pop ? int'(pop_addr) : 0);
    chk("R2", "irq_ack", int'(irq_ack), ack);
    chk("R3", "fetch_cancel", int'(fetch_cancel), stl);
    chk("R3", "push_stb", int'(push_stb), stl);
    if (stl) chk("R3", "push_addr", int'(push_addr), m_ret);
    chk("R6", "pop_stb", int'(pop_stb), pop);
    chk("R11", "ip_load", int'(ip_load), ld);
    chk("R11", "ip_next", int'(ip_next), ipn);
    chk("R5", "in_service", int'(in_service), m_ins);
    chk("R8", "pfx_value", int'(pfx_value), m_pfx_v ? m_pfx : 0);
    chk("R9", "exc_window", int'(exc_window), m_pfx_v);
    chk("R10", "push_pop_overlap", int'(push_stb && pop_stb), 0);
    if (push_stb) begin
      chk("R7", "gap_reti_to_push", (cyc - last_pop_cyc >= 2) ? 1 : 0, 1);
      last_push_cyc = cyc;
    end
    if (pop_stb) last_pop_cyc = cyc;
    if (ack) nins = 1;
    else if (reti_e) nins = 0;
    else if (iw && !stl) nins = iv;
    else nins = m_ins;
    @(posedge clk);
    if (ack) begin m_ret = int'(ret_addr); m_vec = int'(ivec); end
    m_stall = ack;
    m_ins   = nins;
    if (pw && !stl) begin m_pfx_v = 1; m_pfx = pd & 8'hff; end
    else begin m_pfx_v = 0; m_pfx = 0; end
    cyc++;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "in_service", int'(in_service), 0);
    chk("R1", "strobes", int'({irq_ack, fetch_cancel, push_stb, pop_stb, ip_load}), 0);
    chk("R1", "pfx_value", int'(pfx_value), 0);
    @(posedge clk); rst_n = 1'b1;

    // R2: disabled or empty requests are not taken
    tick(0, 8'h04, 0, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 0, 0, 0);
    // R2/R3: basic entry, then R4 block while in service
    tick(1, 8'h01, 0, 0, 0, 0, 0);
    tick(1, 8'h01, 0, 0, 0, 0, 0);
    tick(1, 8'h80, 0, 0, 0, 0, 0);
    // R6/R7: return with request still pending, then re-entry
    tick(1, 8'h80, 1, 0, 0, 0, 0);
    tick(1, 8'h80, 0, 0, 0, 0, 0);
    tick(1, 8'h80, 0, 0, 0, 0, 0);
    // R5: software clears the flag for nesting, then return while pending (R7)
    tick(1, 0, 0, 0, 0, 1, 0);
    tick(1, 8'h10, 1, 0, 0, 0, 0);
    tick(1, 8'h10, 0, 0, 0, 0, 0);
    // R10: decode strobes in the stall cycle are dropped
    tick(1, 0, 1, 1, 8'h5a, 1, 0);
    tick(1, 0, 0, 0, 0, 1, 0);
    // R8/R9: prefix write, request waits out the window
    tick(1, 0, 0, 1, 8'hc3, 0, 0);
    tick(1, 8'h02, 0, 0, 0, 0, 0);
    tick(1, 8'h02, 0, 0, 0, 0, 0);
    tick(1, 0, 1, 0, 0, 0, 0);
    // R9: back-to-back prefix writes keep the window open
    tick(1, 8'h02, 0, 1, 8'h11, 0, 0);
    tick(1, 8'h02, 0, 1, 8'h22, 0, 0);
    tick(1, 8'h02, 0, 0, 0, 0, 0);
    tick(1, 8'h02, 0, 0, 0, 0, 0);
    // R5: software set blocks entry
    tick(1, 0, 1, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 0, 1, 1);
    tick(1, 8'h01, 0, 0, 0, 0, 0);
    tick(1, 8'h01, 0, 0, 0, 1, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom);
      tick((r & 7) != 0, ((r >> 3) & 3) == 0 ? 0 : int'(1) << ((r >> 5) & 7),
           ((r >> 8) & 7) == 0, ((r >> 11) & 7) == 0, (r >> 14) & 8'hff,
           ((r >> 22) & 15) == 0, ((r >> 26) & 1) == 1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule